// File: doc/BRIEF.md
# USB Device IN Endpoint Controller

This block keeps the control state of a single USB device IN endpoint and chooses the handshake returned for each IN token. Software drives it through single-cycle command strobes: enable, disable request, set or clear NAK, set or clear STALL, and a transmit-FIFO flush request. It also supplies a level that selects the endpoint type. The token side delivers an IN token strobe and an end-of-frame strobe. The block answers one clock later with DATA, NAK, STALL or no response. It reads the empty flag of the transmit FIFO that feeds the endpoint.

Three sticky interrupt flags report events, and each is cleared by writing one to it. The first reports that a disable has completed. The second reports a token that met an empty FIFO. The third reports that an isochronous token went without data in the frame that just ended, and it also drives a global status line. A disable request works as a handshake that the hardware finishes on its own. The endpoint drops its enable, the request bit clears itself, and software learns of the result through the first flag. Software can then flush the stale FIFO contents, or it can enable the endpoint again and overwrite them.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: An active-low synchronous reset clears enable, NAK, STALL, the pending-disable bit, all three flags, `hs_valid` and `fifo_flush`.
- R2: A disable request sets `disable_pending` on the next clock edge. If the endpoint is enabled, the following edge clears `ep_enabled` and `disable_pending` and sets flag bit 0 (disable done).
- R3: A disable request on an endpoint that is not enabled is dropped. `disable_pending` clears on the edge after it was set, and flag bit 0 keeps its value.
- R4: `hs_valid` is high for one cycle, the cycle after `tok_in`. Codes are NONE=0, DATA=1, NAK=2, STALL=3. On a non-isochronous endpoint the decision order is: STALL if the STALL bit is set; otherwise NAK if the NAK bit is set or the endpoint is disabled; otherwise NAK if the FIFO is empty; otherwise DATA.
- R5: Once set, STALL stays set, and every non-isochronous token is answered with STALL, until the clear-STALL command.
- R6: STALL set together with a disable on an enabled endpoint lets the disable complete as in R2, with flag bit 0 raised, and STALL stays set.
- R7: With `cfg_ep_type` equal to 1 (isochronous), a token is answered with DATA when the endpoint is enabled and the FIFO is not empty. Otherwise it gets NONE. NAK and STALL are never sent on this endpoint type.
- R8: An isochronous token that arrives while the endpoint is enabled and the FIFO is empty marks the current frame as missed. This includes a token in the same cycle as `frame_end`. At `frame_end` a missed frame sets flag bit 2 and `iso_incomplete`. The mark is then cleared, so a frame without a miss sets nothing.
- R9: A token of any type that arrives while the endpoint is enabled and the FIFO is empty sets flag bit 1.
- R10: Writing one to a bit of `irq_clear` clears that flag on the next edge. A new event for the same flag in the same cycle wins, and the flag stays set.
- R11: A flush request drives `fifo_flush` high for one cycle, the cycle after the request, only while the endpoint is disabled. While the endpoint is enabled the request is ignored.
- R12: The enable command sets `ep_enabled` on the next edge, and this includes an endpoint that was disabled earlier. A later token with data in the FIFO is then answered with DATA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_enable | input | 1 | Enable the endpoint (strobe) |
| cmd_disable | input | 1 | Request endpoint disable (strobe) |
| cmd_set_nak | input | 1 | Set NAK bit (strobe) |
| cmd_clr_nak | input | 1 | Clear NAK bit (strobe) |
| cmd_set_stall | input | 1 | Set STALL bit (strobe) |
| cmd_clr_stall | input | 1 | Clear STALL bit (strobe) |
| cfg_ep_type | input | 2 | Endpoint type: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| cmd_flush | input | 1 | Transmit FIFO flush request (strobe) |
| irq_clear | input | 3 | Write-one-to-clear per flag |
| tok_in | input | 1 | IN token received (strobe) |
| frame_end | input | 1 | End of (micro)frame strobe |
| fifo_empty | input | 1 | Transmit FIFO empty |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | Handshake: 0 none, 1 data, 2 NAK, 3 STALL |
| ep_enabled | output | 1 | Endpoint enable state |
| nak_active | output | 1 | NAK bit |
| stall_active | output | 1 | STALL bit |
| disable_pending | output | 1 | Disable request bit |
| irq_flags | output | 3 | bit0 disable done, bit1 token on empty FIFO, bit2 isochronous incomplete |
| iso_incomplete | output | 1 | Global incomplete-isochronous status |
| fifo_flush | output | 1 | Flush strobe to the transmit FIFO |

## Verification
Tokens are sent to a bulk endpoint under four state combinations: plain, NAK set, STALL with NAK, and STALL alone. These separate each rung of the priority ladder. The FIFO is toggled between full and empty, which tells a data-driven NAK apart from a commanded one. The same token patterns are then replayed on an isochronous endpoint, where STALL and NAK must have no effect. Frames with and without an empty-FIFO token, and a flag clear that coincides with a new event, show whether the missed-frame mark and the flag priority are kept per frame. Disable requests on an enabled and on an idle endpoint, and flush requests before and after the disable, separate the completion path from the path where the request is ignored.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
  localparam int HS_W      = 2;
  localparam int TYPE_W    = 2;
  localparam int NUM_FLAGS = 3;

  localparam int FLAG_DIS_DONE  = 0;
  localparam int FLAG_TOK_EMPTY = 1;
  localparam int FLAG_ISO_MISS  = 2;

  typedef enum logic [HS_W-1:0] {
    HS_NONE  = 2'd0,
    HS_DATA  = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  typedef enum logic [TYPE_W-1:0] {
    EP_CTRL = 2'd0,
    EP_ISO  = 2'd1,
    EP_BULK = 2'd2,
    EP_INTR = 2'd3
  } ep_type_e;

  // Handshake ladder for one token, given the endpoint state at token time.
  function automatic hs_e pick_handshake(logic iso, logic en, logic stall,
                                         logic nak, logic empty);
    hs_e r;
    if (iso) begin
      r = (en && !empty) ? HS_DATA : HS_NONE;
    end else if (stall) begin
      r = HS_STALL;
    end else if (nak || !en || empty) begin
      r = HS_NAK;
    end else begin
      r = HS_DATA;
    end
    return r;
  endfunction
endpackage

// File: rtl/usb_in_ep_state.sv
module usb_in_ep_state (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_enable,
  input  logic cmd_disable,
  input  logic cmd_set_nak,
  input  logic cmd_clr_nak,
  input  logic cmd_set_stall,
  input  logic cmd_clr_stall,
  output logic en,
  output logic nak,
  output logic stall,
  output logic dis_pend,
  output logic dis_done
);
  logic dis_drop;

  // Completion happens on the edge after the request bit is seen.
  assign dis_done = dis_pend && en;
  assign dis_drop = dis_pend && !en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      nak      <= 1'b0;
      stall    <= 1'b0;
      dis_pend <= 1'b0;
    end else begin
      if (dis_done)        en <= 1'b0;
      else if (cmd_enable) en <= 1'b1;

      if (dis_pend)         dis_pend <= 1'b0;
      else if (cmd_disable) dis_pend <= 1'b1;

      if (cmd_set_nak)      nak <= 1'b1;
      else if (cmd_clr_nak) nak <= 1'b0;

      if (cmd_set_stall)      stall <= 1'b1;
      else if (cmd_clr_stall) stall <= 1'b0;
    end
  end

  a_r2_disable_completes: assert property (@(posedge clk) disable iff (!rst_n)
    dis_done |=> (!en && !dis_pend));
  a_r3_idle_disable_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    dis_drop |=> !dis_pend);
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !cmd_clr_stall) |=> stall);
endmodule

// File: rtl/usb_in_ep_resp.sv
module usb_in_ep_resp
  import usb_in_ep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_in,
  input  logic              frame_end,
  input  logic              fifo_empty,
  input  logic [TYPE_W-1:0] ep_type,
  input  logic              en,
  input  logic              nak,
  input  logic              stall,
  output logic              hs_valid,
  output logic [HS_W-1:0]   hs_code,
  output logic              tok_empty_evt,
  output logic              iso_incomp_evt
);
  logic is_iso;
  logic iso_miss;
  logic miss_pend;
  hs_e  decision;

  assign is_iso         = (ep_type == EP_ISO);
  assign decision       = pick_handshake(is_iso, en, stall, nak, fifo_empty);
  assign tok_empty_evt  = tok_in && en && fifo_empty;
  assign iso_miss       = tok_empty_evt && is_iso;
  assign iso_incomp_evt = frame_end && (miss_pend || iso_miss);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid  <= 1'b0;
      hs_code   <= HS_NONE;
      miss_pend <= 1'b0;
    end else begin
      hs_valid <= tok_in;
      if (tok_in) hs_code <= decision;
      if (frame_end)     miss_pend <= 1'b0;
      else if (iso_miss) miss_pend <= 1'b1;
    end
  end

  a_r4_stall_first: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && !is_iso && stall) |=> (hs_valid && hs_code == HS_STALL));
  a_r7_iso_no_nak_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && is_iso) |=> (hs_code == HS_NONE || hs_code == HS_DATA));
  a_r8_miss_cleared_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !miss_pend);
endmodule

// File: rtl/usb_in_ep_irq.sv
module usb_in_ep_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_w1,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_evt[i]) flags[i] <= 1'b1;
      else if (clr_w1[i])  flags[i] <= 1'b0;
    end

    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[i] |=> flags[i]);
    a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w1[i] && !set_evt[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      cmd_enable,
  input  logic                                      cmd_disable,
  input  logic                                      cmd_set_nak,
  input  logic                                      cmd_clr_nak,
  input  logic                                      cmd_set_stall,
  input  logic                                      cmd_clr_stall,
  input  logic [usb_in_ep_pkg::TYPE_W-1:0]          cfg_ep_type,
  input  logic                                      cmd_flush,
  input  logic [usb_in_ep_pkg::NUM_FLAGS-1:0]       irq_clear,
  input  logic                                      tok_in,
  input  logic                                      frame_end,
  input  logic                                      fifo_empty,
  output logic                                      hs_valid,
  output logic [usb_in_ep_pkg::HS_W-1:0]            hs_code,
  output logic                                      ep_enabled,
  output logic                                      nak_active,
  output logic                                      stall_active,
  output logic                                      disable_pending,
  output logic [usb_in_ep_pkg::NUM_FLAGS-1:0]       irq_flags,
  output logic                                      iso_incomplete,
  output logic                                      fifo_flush
);
  import usb_in_ep_pkg::*;

  logic                 dis_done;
  logic                 tok_empty_evt;
  logic                 iso_incomp_evt;
  logic                 flush_ok;
  logic [NUM_FLAGS-1:0] set_evt;

  usb_in_ep_state u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_enable   (cmd_enable),
    .cmd_disable  (cmd_disable),
    .cmd_set_nak  (cmd_set_nak),
    .cmd_clr_nak  (cmd_clr_nak),
    .cmd_set_stall(cmd_set_stall),
    .cmd_clr_stall(cmd_clr_stall),
    .en           (ep_enabled),
    .nak          (nak_active),
    .stall        (stall_active),
    .dis_pend     (disable_pending),
    .dis_done     (dis_done)
  );

  usb_in_ep_resp u_resp (
    .clk           (clk),
    .rst_n         (rst_n),
    .tok_in        (tok_in),
    .frame_end     (frame_end),
    .fifo_empty    (fifo_empty),
    .ep_type       (cfg_ep_type),
    .en            (ep_enabled),
    .nak           (nak_active),
    .stall         (stall_active),
    .hs_valid      (hs_valid),
    .hs_code       (hs_code),
    .tok_empty_evt (tok_empty_evt),
    .iso_incomp_evt(iso_incomp_evt)
  );

  always_comb begin
    set_evt                 = '0;
    set_evt[FLAG_DIS_DONE]  = dis_done;
    set_evt[FLAG_TOK_EMPTY] = tok_empty_evt;
    set_evt[FLAG_ISO_MISS]  = iso_incomp_evt;
  end

  usb_in_ep_irq #(.N(NUM_FLAGS)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(set_evt),
    .clr_w1 (irq_clear),
    .flags  (irq_flags)
  );

  assign iso_incomplete = irq_flags[FLAG_ISO_MISS];

  // Flush only honoured once the endpoint is no longer enabled.
  assign flush_ok = cmd_flush && !ep_enabled;

  always_ff @(posedge clk) begin
    if (!rst_n) fifo_flush <= 1'b0;
    else        fifo_flush <= flush_ok;
  end

  a_r11_no_flush_while_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ep_enabled |=> !fifo_flush);
  a_r11_flush_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_flush && !flush_ok) |=> !fifo_flush);
endmodule

// File: tb/usb_in_ep_ctrl_test.sv
module usb_in_ep_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_enable = 0, cmd_disable = 0, cmd_set_nak = 0, cmd_clr_nak = 0;
  logic cmd_set_stall = 0, cmd_clr_stall = 0, cmd_flush = 0;
  logic [1:0] cfg_ep_type = 2'd2;
  logic [2:0] irq_clear = 3'd0;
  logic tok_in = 0, frame_end = 0, fifo_empty = 0;
  logic hs_valid, ep_enabled, nak_active, stall_active, disable_pending;
  logic iso_incomplete, fifo_flush;
  logic [1:0] hs_code;
  logic [2:0] irq_flags;

  int checks = 0;
  int errors = 0;

  // Reference model state
  bit m_en, m_nak, m_stall, m_dis, m_hv, m_flush, m_miss;
  int m_hc;
  bit [2:0] m_flags;

  always #2.5 clk = ~clk;

  usb_in_ep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .cmd_set_nak(cmd_set_nak), .cmd_clr_nak(cmd_clr_nak),
    .cmd_set_stall(cmd_set_stall), .cmd_clr_stall(cmd_clr_stall),
    .cfg_ep_type(cfg_ep_type), .cmd_flush(cmd_flush), .irq_clear(irq_clear),
    .tok_in(tok_in), .frame_end(frame_end), .fifo_empty(fifo_empty),
    .hs_valid(hs_valid), .hs_code(hs_code), .ep_enabled(ep_enabled),
    .nak_active(nak_active), .stall_active(stall_active),
    .disable_pending(disable_pending), .irq_flags(irq_flags),
    .iso_incomplete(iso_incomplete), .fifo_flush(fifo_flush)
  );

  // Behavioural model written from the requirements, stepped every edge.
  always @(posedge clk) begin
    bit iso, n_en, n_dis, n_nak, n_stall, miss_now;
    bit [2:0] ev;
    int code;
    if (!rst_n) begin
      m_en = 0; m_nak = 0; m_stall = 0; m_dis = 0; m_hv = 0; m_hc = 0;
      m_flush = 0; m_miss = 0; m_flags = 0;
    end else begin
      iso = (cfg_ep_type == 2'd1);
      if (iso) code = (m_en && !fifo_empty) ? 1 : 0;
      else if (m_stall) code = 3;
      else if (m_nak || !m_en) code = 2;
      else if (fifo_empty) code = 2;
      else code = 1;
      ev = 0;
      ev[1] = tok_in && m_en && fifo_empty;
      miss_now = ev[1] && iso;
      ev[2] = frame_end && (m_miss || miss_now);
      ev[0] = m_dis && m_en;
      n_en = m_en; n_dis = m_dis; n_nak = m_nak; n_stall = m_stall;
      if (m_dis) begin
        if (m_en) n_en = 0;
        n_dis = 0;
      end else if (cmd_disable) n_dis = 1;
      if (!(m_dis && m_en) && cmd_enable) n_en = 1;
      if (cmd_set_nak) n_nak = 1; else if (cmd_clr_nak) n_nak = 0;
      if (cmd_set_stall) n_stall = 1; else if (cmd_clr_stall) n_stall = 0;
      m_flush = cmd_flush && !m_en;
      if (frame_end) m_miss = 0; else if (miss_now) m_miss = 1;
      for (int i = 0; i < 3; i++)
        if (ev[i]) m_flags[i] = 1; else if (irq_clear[i]) m_flags[i] = 0;
      m_hv = tok_in;
      if (tok_in) m_hc = code;
      m_en = n_en; m_dis = n_dis; m_nak = n_nak; m_stall = n_stall;
    end
  end

  task automatic expect_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    expect_val("R4 hs_valid vs model", hs_valid, m_hv);
    if (m_hv) expect_val("R4/R7 hs_code vs model", hs_code, m_hc);
    expect_val("R2 enable vs model", ep_enabled, m_en);
    expect_val("R3 disable_pending vs model", disable_pending, m_dis);
    expect_val("R4 nak vs model", nak_active, m_nak);
    expect_val("R5 stall vs model", stall_active, m_stall);
    expect_val("R10 flags vs model", irq_flags, m_flags);
    expect_val("R8 iso_incomplete vs model", iso_incomplete, m_flags[2]);
    expect_val("R11 flush vs model", fifo_flush, m_flush);
  endtask

  task automatic tick();
    @(negedge clk);
    compare_model();
  endtask

  task automatic token(bit empty);
    fifo_empty = empty; tok_in = 1; tick(); tok_in = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cmd_enable = 1; cmd_set_stall = 1; cmd_set_nak = 1; cmd_disable = 1;
    irq_clear = 0; tick(); tick();
    cmd_enable = 0; cmd_set_stall = 0; cmd_set_nak = 0; cmd_disable = 0;
    // R1: reset state
    expect_val("R1 enable after reset", ep_enabled, 0);
    expect_val("R1 stall after reset", stall_active, 0);
    expect_val("R1 flags after reset", irq_flags, 0);
    rst_n = 1;
    cfg_ep_type = 2'd2;
    cmd_enable = 1; tick(); cmd_enable = 0;
    expect_val("R12 enable set", ep_enabled, 1);
    token(0); expect_val("R4 plain DATA", hs_code, 1);
    token(1); expect_val("R4 empty NAK", hs_code, 2);
    expect_val("R9 token on empty flag", irq_flags[1], 1);
    irq_clear = 3'b010; tick(); irq_clear = 0;
    expect_val("R10 clear flag", irq_flags[1], 0);
    irq_clear = 3'b010; token(1); irq_clear = 0;
    expect_val("R10 event wins over clear", irq_flags[1], 1);
    irq_clear = 3'b111; tick(); irq_clear = 0;
    cmd_set_nak = 1; tick(); cmd_set_nak = 0;
    token(0); expect_val("R4 NAK bit", hs_code, 2);
    cmd_set_stall = 1; tick(); cmd_set_stall = 0;
    token(0); expect_val("R4 STALL beats NAK", hs_code, 3);
    cmd_clr_nak = 1; tick(); cmd_clr_nak = 0;
    for (int k = 0; k < 3; k++) begin
      token(0); expect_val("R5 STALL persists", hs_code, 3);
    end
    cmd_flush = 1; tick(); cmd_flush = 0; tick();
    expect_val("R11 flush ignored while enabled", fifo_flush, 0);
    cmd_disable = 1; cmd_set_nak = 1; tick(); cmd_disable = 0; cmd_set_nak = 0;
    expect_val("R2 disable bit set", disable_pending, 1);
    tick();
    expect_val("R2 enable dropped", ep_enabled, 0);
    expect_val("R2 disable bit self-clears", disable_pending, 0);
    expect_val("R6 disabled flag with stall", irq_flags[0], 1);
    expect_val("R6 stall kept", stall_active, 1);
    token(0); expect_val("R6 STALL while disabled", hs_code, 3);
    cmd_clr_stall = 1; cmd_clr_nak = 1; tick(); cmd_clr_stall = 0; cmd_clr_nak = 0;
    token(0); expect_val("R4 disabled gives NAK", hs_code, 2);
    cmd_flush = 1; tick(); cmd_flush = 0;
    expect_val("R11 flush pulse", fifo_flush, 1);
    tick(); expect_val("R11 flush one cycle", fifo_flush, 0);
    irq_clear = 3'b001; tick(); irq_clear = 0;
    cmd_disable = 1; tick(); cmd_disable = 0; tick();
    expect_val("R3 idle disable clears", disable_pending, 0);
    expect_val("R3 no disabled flag", irq_flags[0], 0);
    cmd_enable = 1; tick(); cmd_enable = 0;
    token(0); expect_val("R12 DATA after re-enable", hs_code, 1);
    // Isochronous
    cfg_ep_type = 2'd1;
    token(0); expect_val("R7 iso DATA", hs_code, 1);
    cmd_set_stall = 1; cmd_set_nak = 1; tick(); cmd_set_stall = 0; cmd_set_nak = 0;
    token(0); expect_val("R7 iso ignores STALL/NAK", hs_code, 1);
    cmd_clr_stall = 1; cmd_clr_nak = 1; tick(); cmd_clr_stall = 0; cmd_clr_nak = 0;
    irq_clear = 3'b111; tick(); irq_clear = 0;
    token(1); expect_val("R7 iso empty NONE", hs_code, 0);
    expect_val("R7 iso still valid", hs_valid, 1);
    expect_val("R8 not before frame end", iso_incomplete, 0);
    frame_end = 1; tick(); frame_end = 0;
    expect_val("R8 incomplete at frame end", iso_incomplete, 1);
    irq_clear = 3'b100; tick(); irq_clear = 0;
    token(0); frame_end = 1; tick(); frame_end = 0;
    expect_val("R8 clean frame sets nothing", iso_incomplete, 0);
    fifo_empty = 1; tok_in = 1; frame_end = 1; tick(); tok_in = 0; frame_end = 0;
    expect_val("R8 same-cycle miss counts", iso_incomplete, 1);
    cmd_disable = 1; tick(); cmd_disable = 0; tick();
    token(0); expect_val("R7 disabled iso NONE", hs_code, 0);
    repeat (3) tick();
    finish_run();
  end
endmodule